// File: doc/BRIEF.md
# MDIO Management Command Controller

This block gives software access to the management registers of an Ethernet PHY. It has two 32-bit registers on a simple register bus, a command word and a data word. Software writes one command word that carries the PHY address, the register address, an opcode and, for a write, sixteen bits of payload. If that word has its start bit set and names a legal Clause 22 operation, the controller runs one complete management frame on MDC/MDIO. While the frame is running, the start bit reads back as 1. When the frame ends, the start bit clears by itself.

The data word returns the sixteen bits from the last read in its low half, and an idle flag that always reads as the inverse of the start bit. Software can poll either bit to see when the command has finished. If a command asks for a non-Clause-22 frame, or its opcode is missing or ambiguous, the controller drops it on the spot and the pins stay untouched. MDC comes from a parameterised divider of the system clock and runs only while a frame is in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word reads 0x0000_0000, the data word reads 0x0001_0000 (only the idle flag set), MDC is low and MDIO is released (output enable low).
- R2: `regSelData`=0 selects the command word and `regSelData`=1 selects the data word. Command fields: bit 31 start, bit 28 Clause 22 select, bit 27 read opcode, bit 26 write opcode, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 write payload. A command written with bit 31 clear is stored as written and starts nothing.
- R3: A command with bits 31 and 28 set and exactly one of bits 27/26 set starts a frame. The start bit reads 1 and the idle flag (data bit 16) reads 0 until the frame ends, and then they read 0 and 1. The idle flag is always the inverse of the start bit.
- R4: A write frame is 64 bits, MSB first, with MDIO driven throughout: 32 ones, 01, 01, the PHY address, the register address, 10, then the payload.
- R5: A read frame drives 32 ones, 01, 10, the PHY address and the register address (46 bits). It then releases MDIO for the two turnaround bits and the 16 data bits.
- R6: When a read ends, the 16 bits sampled from MDIO (first bit = MSB) appear in data bits 15:0, and data bits 31:17 keep their value.
- R7: A command with bit 31 set and bit 28 clear is rejected. It is stored with bit 31 cleared, no MDC edge occurs, and the controller stays idle.
- R8: A command with bit 31 and bit 28 set and bits 27/26 both clear or both set is rejected in the same way as in R7.
- R9: Software writes to the data word update only bits 31:17. Bits 15:0 and the idle flag ignore them.
- R10: Writes to the command word are ignored while a frame is in progress, and the frame on the pins is unaffected.
- R11: MDC has a period of 2×`MDC_HALF` system clocks, makes exactly 64 rising edges per frame, and is low whenever no frame is in progress.
- R12: MDIO output data changes only on MDC falling edges (it never changes while MDC is high), and read data is sampled on MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSelData | input | 1 | Word select: 0 command word, 1 data word |
| regWrEn | input | 1 | Register write strobe, one cycle per 32-bit write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut; low releases the line |
| mdioIn | input | 1 | Management data received from the PHY |

## Verification
The bench builds the block with `MDC_HALF` = 3. That gives an MDC period of six system clocks, with the high and low phases each three clocks long, so the divider's counting path is exercised, not its one-clock-per-phase variant. One frame then takes a few hundred cycles, short enough for the bench to capture every bit of several write and read frames at the MDC rising edges, to play a PHY that answers during the read data phase, and to land command writes in the middle of a running frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_LEN = 64;  // preamble through data
  localparam int PRE_LEN   = 32;
  localparam int TA_IDX    = 46;  // first turnaround bit
  localparam int DATA_IDX  = 48;  // first data bit
  localparam int DATA_W    = 16;

  localparam int CMD_START = 31;
  localparam int CMD_C22   = 28;
  localparam int CMD_RD    = 27;
  localparam int CMD_WR    = 26;
  localparam int IDLE_BIT  = 16;

  typedef struct packed {
    logic load;    // preload frame shifter
    logic shift;   // advance to next output bit (MDC falling)
    logic sample;  // capture one read bit (MDC rising)
    logic finish;  // frame complete
  } engStrobe_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int MDC_HALF = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic mdc,
  output logic riseTick,
  output logic fallTick
);
  localparam int CW = $clog2(MDC_HALF + 1);

  logic terminal;

  generate
    if (MDC_HALF == 1) begin : g_fast
      assign terminal = en;
    end else begin : g_cnt
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !en) divCnt <= '0;
        else if (divCnt == CW'(MDC_HALF - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign terminal = en && (divCnt == CW'(MDC_HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || !en) mdc <= 1'b0;
    else if (terminal) mdc <= ~mdc;
  end

  assign riseTick = terminal && !mdc;
  assign fallTick = terminal && mdc;
endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       launch,
  input  logic       isRead,
  output engStrobe_t strb,
  output logic       running,
  output logic       mdc,
  output logic       mdioOe
);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_LEN - 1);
  localparam logic [BW-1:0] TA_BIT    = BW'(TA_IDX);
  localparam logic [BW-1:0] DATA_BIT  = BW'(DATA_IDX);

  logic [BW-1:0] bitCnt;
  logic          riseTick;
  logic          fallTick;

  mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdcGen (
    .clk      (clk),
    .rstN     (rstN),
    .en       (running),
    .mdc      (mdc),
    .riseTick (riseTick),
    .fallTick (fallTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      bitCnt  <= '0;
    end else if (!running) begin
      if (launch) begin
        running <= 1'b1;
        bitCnt  <= '0;
      end
    end else if (fallTick) begin
      if (bitCnt == LAST_BIT) running <= 1'b0;
      else bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load   = !running && launch;
    strb.shift  = running && fallTick && (bitCnt != LAST_BIT);
    strb.finish = running && fallTick && (bitCnt == LAST_BIT);
    strb.sample = running && riseTick && isRead && (bitCnt >= DATA_BIT);
  end

  assign mdioOe = running && (!isRead || (bitCnt < TA_BIT));
endmodule

// File: rtl/mdio_reg_datapath.sv
module mdio_reg_datapath
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSelData,
  input  logic        regWrEn,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  engStrobe_t  strb,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        launch,
  output logic        isRead,
  output logic        cmdBusy,
  output logic [31:0] cmdWord
);
  logic [31:17]          dataHi;
  logic [DATA_W-1:0]     dataLo;
  logic [DATA_W-1:0]     rxShift;
  logic [FRAME_LEN-1:0]  txShift;
  logic [FRAME_LEN-1:0]  frameWord;
  logic                  cmdWrite;
  logic                  goodCmd;
  logic                  wantRead;

  assign cmdBusy  = cmdWord[CMD_START];
  assign isRead   = cmdWord[CMD_RD];
  assign cmdWrite = regWrEn && !regSelData && !cmdBusy;
  assign goodCmd  = regWdata[CMD_START] && regWdata[CMD_C22]
                    && (regWdata[CMD_RD] ^ regWdata[CMD_WR]);
  assign launch   = cmdWrite && goodCmd;
  assign wantRead = regWdata[CMD_RD];

  always_comb begin
    frameWord = {{PRE_LEN{1'b1}}, 2'b01,
                 wantRead ? 2'b10 : 2'b01,
                 regWdata[25:21], regWdata[20:16],
                 wantRead ? 2'b00 : 2'b10,
                 wantRead ? 16'h0000 : regWdata[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdWord <= '0;
    else if (cmdWrite) cmdWord <= {goodCmd, regWdata[30:0]};
    else if (strb.finish) cmdWord[CMD_START] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataHi <= '0;
    else if (regWrEn && regSelData) dataHi <= regWdata[31:17];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataLo  <= '0;
      rxShift <= '0;
    end else begin
      if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strb.finish && isRead) dataLo <= rxShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txShift <= '0;
    else if (strb.load) txShift <= frameWord;
    else if (strb.shift) txShift <= {txShift[FRAME_LEN-2:0], 1'b0};
    else if (strb.finish) txShift <= '0;
  end

  assign mdioOut  = txShift[FRAME_LEN-1];
  assign regRdata = regSelData ? {dataHi, ~cmdBusy, dataLo} : cmdWord;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSelData,
  input  logic        regWrEn,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  engStrobe_t  strb;
  logic        launch;
  logic        isRead;
  logic        cmdBusy;
  logic        running;
  logic [31:0] cmdWord;

  mdio_reg_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regSelData (regSelData),
    .regWrEn    (regWrEn),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .strb       (strb),
    .mdioIn     (mdioIn),
    .mdioOut    (mdioOut),
    .launch     (launch),
    .isRead     (isRead),
    .cmdBusy    (cmdBusy),
    .cmdWord    (cmdWord)
  );

  mdio_seq_ctrl #(.MDC_HALF(MDC_HALF)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .launch  (launch),
    .isRead  (isRead),
    .strb    (strb),
    .running (running),
    .mdc     (mdc),
    .mdioOe  (mdioOe)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regSelData,
  input logic        regWrEn,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        cmdBusy,
  input logic        running,
  input logic [31:0] cmdWord
);
  // R3: the start bit in the register file tracks the frame sequencer
  assert_busy_agree_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy == running);

  // R3: idle flag as seen on the bus is the inverse of a running frame
  assert_idle_mirror_R3: assert property (@(posedge clk) disable iff (!rstN)
    regSelData |-> (regRdata[16] == !running));

  // R7: start without Clause 22 select never starts a frame
  assert_reject_c45_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdBusy && regWrEn && !regSelData && regWdata[31] && !regWdata[28])
      |=> (!running && !cmdBusy));

  // R8: missing or double opcode never starts a frame
  assert_reject_op_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdBusy && regWrEn && !regSelData && regWdata[31]
      && (regWdata[27] == regWdata[26])) |=> (!running && !cmdBusy));

  // R10: command fields hold while a frame is in progress
  assert_cmd_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && regWrEn && !regSelData) |=> (cmdWord[30:0] == $past(cmdWord[30:0])));

  // R11: pins quiet when no frame runs
  assert_mdc_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!mdc && !mdioOe));

  // R12: output data never moves while MDC is high
  assert_out_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSelData (regSelData),
  .regWrEn    (regWrEn),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .mdc        (mdc),
  .mdioOut    (mdioOut),
  .mdioOe     (mdioOe),
  .cmdBusy    (cmdBusy),
  .running    (running),
  .cmdWord    (cmdWord)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSelData = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench PHY and capture state
  int          riseCnt = 0;
  logic [63:0] capOut;
  logic [63:0] capOe;
  logic [15:0] phyResp = 16'h0000;
  time         t0, t1;
  int          highChanges = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .regSelData(regSelData), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = (riseCnt >= 48 && riseCnt < 64) ? phyResp[63 - riseCnt] : 1'b1;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[63 - riseCnt] = mdioOut;
      capOe[63 - riseCnt]  = mdioOe;
    end
    if (riseCnt == 0) t0 = $time;
    if (riseCnt == 1) t1 = $time;
    riseCnt = riseCnt + 1;
  end

  always @(mdioOut) if (mdc === 1'b1) highChanges = highChanges + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [31:0] val);
    @(negedge clk);
    regSelData = sel; regWdata = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [31:0] val);
    @(negedge clk);
    regSelData = sel;
    #1 val = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      busRead(1'b1, v);
      if (v[16]) break;
    end
  endtask

  task automatic clearCapture();
    riseCnt = 0; capOut = '0; capOe = '0; highChanges = 0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(1'b0, v); check("R1 cmd after reset", 64'(v), 64'h0);
    busRead(1'b1, v); check("R1 data after reset", 64'(v), 64'h0001_0000);
    check("R1 mdc/oe after reset", {62'h0, mdc, mdioOe}, 64'h0);
    busWrite(1'b0, 32'h0123_4567);
    busRead(1'b0, v); check("R2 plain cmd store", 64'(v), 64'h0123_4567);
    repeat (20) @(negedge clk);
    check("R2 no frame without start", 64'(riseCnt), 64'd0);
  endtask

  task automatic testDataReg();
    logic [31:0] v;
    busWrite(1'b1, 32'hFFFF_FFFF);
    busRead(1'b1, v); check("R9 data write all ones", 64'(v), 64'hFFFF_0000);
    busWrite(1'b1, 32'hABCD_1234);
    busRead(1'b1, v); check("R9 data write pattern", 64'(v), 64'hABCD_0000);
    busRead(1'b0, v); check("R2 cmd untouched by data write", 64'(v), 64'h0123_4567);
  endtask

  task automatic testWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] v, cmd;
    logic [63:0] exp;
    cmd = 32'h9400_0000 | {6'h0, phy, rg, d};
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    clearCapture();
    busWrite(1'b0, cmd);
    busRead(1'b0, v); check("R3 start bit while busy", 64'(v), 64'(cmd));
    busRead(1'b1, v); check("R3 idle low while busy", 64'(v[16]), 64'd0);
    waitIdle();
    busRead(1'b0, v); check("R3 start cleared at end", 64'(v), 64'(cmd & 32'h7FFF_FFFF));
    check("R4 write frame bits", capOut, exp);
    check("R4 write frame driven", capOe, {64{1'b1}});
    check("R11 rising edges per frame", 64'(riseCnt), 64'd64);
    check("R11 mdc period", 64'(t1 - t0), 64'(2 * HALF * 10));
    check("R12 no change while mdc high", 64'(highChanges), 64'd0);
  endtask

  task automatic testRead(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] resp, input bit poke);
    logic [31:0] v, cmd;
    logic [63:0] exp;
    cmd = 32'h9800_0000 | {6'h0, phy, rg, 16'h0000};
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
    phyResp = resp;
    clearCapture();
    busWrite(1'b0, cmd);
    if (poke) begin
      repeat (60) @(negedge clk);
      busWrite(1'b0, 32'h9400_FFFF);
      busRead(1'b0, v); check("R10 cmd write ignored while busy", 64'(v), 64'(cmd));
    end
    waitIdle();
    check("R5 read header bits", {capOut[63:18], 18'h0}, exp);
    check("R5 read release pattern", capOe, {{46{1'b1}}, 18'h0});
    busRead(1'b1, v); check("R6 read result with upper bits kept", 64'(v), 64'({16'hABCD, resp}));
    check("R12 no change while mdc high", 64'(highChanges), 64'd0);
  endtask

  task automatic testReject(input string req, input logic [31:0] cmd);
    logic [31:0] v;
    clearCapture();
    busWrite(1'b0, cmd);
    busRead(1'b0, v); check({req, " stored without start"}, 64'(v), 64'(cmd & 32'h7FFF_FFFF));
    busRead(1'b1, v); check({req, " idle flag set"}, 64'(v[16]), 64'd1);
    repeat (40) @(negedge clk);
    check({req, " no mdc activity"}, 64'(riseCnt), 64'd0);
    check({req, " mdio released"}, 64'(mdioOe), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDataReg();
    testWrite(5'h12, 5'h03, 16'hA55A);
    testWrite(5'h01, 5'h1F, 16'h0001);
    testRead(5'h07, 5'h02, 16'hBEEF, 1'b1);
    testRead(5'h1F, 5'h10, 16'h1234, 1'b0);
    testReject("R7", 32'h8400_5555);
    testReject("R8 both ops", 32'h9C00_0000);
    testReject("R8 no op", 32'h9000_0000);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule